// File: doc/BRIEF.md
# Serial dual-channel DAC register interface

This block is the digital front end of a dual 12-bit voltage-output converter. A host writes 16-bit command words over three wires: a serial clock, a serial data line and an active-low frame select. All three inputs are oversampled on a fast system clock. Each bit is captured on a rising serial clock edge while the frame select is low. When the frame select returns high, the word held in the shift register is decoded. Its 12-bit two's-complement data field is written into one of two channel registers, and its shutdown bit is latched.

Each channel presents its stored code and an offset-binary copy of it for the converter core. A one-cycle load strobe marks the cycle in which the addressed channel takes a new value. The command decode always uses the last bits shifted in. Frames longer than a word keep only the newest 16 bits. Frames shorter than a word reuse whatever the shift register already holds.

Top module: `dual_dac_serial_if`

## Requirements
- R1: After reset, both codes are 0x000, both offset-binary outputs are 0x800, the shutdown flag and both strobes are 0, and the shift register is zero, so a frame with no clock edges loads 0x000 into channel A.
- R2: Bits are taken most significant first, one per rising serial clock edge while frame select is low. In the 16-bit word, bit 15 is the address, bit 13 is shutdown and bits 11:0 are the data. On a low-to-high frame select the data is transferred unchanged, with codes 0x7FF, 0x800, 0xFFF, 0x801 and 0x000 all kept as sent. The outputs change on the third system clock edge counted from the first edge that samples frame select high.
- R3: Address 0 writes channel A and address 1 writes channel B. The other channel keeps its code, and a code changes only in a cycle where its strobe is high.
- R4: Serial clock edges while frame select is high leave the shift register unchanged.
- R5: When more than 16 clock edges arrive in one frame, only the last 16 bits are decoded.
- R6: When fewer than 16 clock edges arrive, the shift register is not cleared at frame start, and the transfer decodes its current contents.
- R7: The shutdown flag takes bit 13 on every transfer, whichever channel is addressed, and holds between transfers.
- R8: Bits 14 and 12 of the word have no effect on either code or on the shutdown flag.
- R9: Each offset-binary output equals its channel code with bit 11 inverted.
- R10: Each transfer raises the strobe of the addressed channel alone, for exactly one cycle, in the same cycle in which its new code appears.
- R11: A serial clock rise sampled in the same system cycle as the frame select rise is not shifted in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, rising edge captures a bit |
| sdat_i | input | 1 | Serial data, most significant bit first |
| frame_n_i | input | 1 | Frame select, active low; rising edge transfers |
| code_a_o | output | 12 | Channel A two's-complement code |
| code_b_o | output | 12 | Channel B two's-complement code |
| ofs_a_o | output | 12 | Channel A offset-binary code |
| ofs_b_o | output | 12 | Channel B offset-binary code |
| shutdown_o | output | 1 | Shutdown flag from the last transfer |
| load_a_o | output | 1 | One-cycle strobe: channel A loaded |
| load_b_o | output | 1 | One-cycle strobe: channel B loaded |

## Verification
The end-of-frame transfer and a serial clock capture can land in the same system cycle, and the transfer must then win. The bench provokes this by raising the serial clock with a one on the data line in the same cycle as the frame select rises. The loaded code must equal the 16-bit word sent before, with no extra bit shifted in. A per-cycle reference model, built from delayed input samples, tracks every output. It also covers the case in which one channel loads while the other must hold still.

// File: rtl/dac_if_pkg.sv
package dac_if_pkg;
  parameter int DATA_W   = 12;
  parameter int CTRL_W   = 4;
  parameter int WORD_W   = DATA_W + CTRL_W;
  parameter int N_CH     = 2;
  // Field positions inside the received word (decoded by the channel bank)
  parameter int ADDR_BIT = WORD_W - 1;
  parameter int SD_BIT   = WORD_W - 3;
  // Reset values of the synchronized inputs {frame_n, sdat, sclk}
  parameter logic [2:0] IN_IDLE = 3'b100;

  typedef enum logic {CH_A = 1'b0, CH_B = 1'b1} ch_sel_e;
endpackage

// File: rtl/dac_sync2.sv
module dac_sync2 #(
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              sdat_s,
  input  logic              frame_n_s,
  output logic [WORD_W-1:0] shift_q,
  output logic              frame_end_o
);
  logic              sclk_prev_q;
  logic              frame_prev_q;
  logic              shift_en;
  logic [WORD_W-1:0] shift_d;

  // next state
  always_comb begin
    shift_en    = sclk_s & ~sclk_prev_q & ~frame_n_s;
    frame_end_o = frame_n_s & ~frame_prev_q;
    shift_d     = shift_q;
    if (shift_en) shift_d = {shift_q[WORD_W-2:0], sdat_s};
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q  <= 1'b0;
      frame_prev_q <= 1'b1;
      shift_q      <= '0;
    end else begin
      sclk_prev_q  <= sclk_s;
      frame_prev_q <= frame_n_s;
      if (shift_en) shift_q <= shift_d;
    end
  end
endmodule

// File: rtl/dac_chan_bank.sv
module dac_chan_bank #(
  parameter int DATA_W = 12,
  parameter int N_CH   = 2,
  localparam int SEL_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          xfer_i,
  input  logic [SEL_W-1:0]              sel_i,
  input  logic [DATA_W-1:0]             data_i,
  input  logic                          sd_i,
  output logic [N_CH-1:0][DATA_W-1:0]   code_o,
  output logic [N_CH-1:0][DATA_W-1:0]   ofs_o,
  output logic [N_CH-1:0]               strobe_o,
  output logic                          sd_o
);
  logic sd_q;
  logic sd_d;

  always_comb sd_d = xfer_i ? sd_i : sd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sd_q <= 1'b0;
    else        sd_q <= sd_d;
  end
  assign sd_o = sd_q;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic              hit;
    logic [DATA_W-1:0] code_d;
    logic [DATA_W-1:0] code_q;
    logic              stb_q;

    always_comb begin
      hit    = xfer_i && (sel_i == SEL_W'(c));
      code_d = hit ? data_i : code_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        code_q <= '0;
        stb_q  <= 1'b0;
      end else begin
        code_q <= code_d;
        stb_q  <= hit;
      end
    end

    assign code_o[c]   = code_q;
    assign strobe_o[c] = stb_q;
    assign ofs_o[c]    = {~code_q[DATA_W-1], code_q[DATA_W-2:0]};
  end
endmodule

// File: rtl/dual_dac_serial_if.sv
module dual_dac_serial_if
  import dac_if_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              sdat_i,
  input  logic              frame_n_i,
  output logic [DATA_W-1:0] code_a_o,
  output logic [DATA_W-1:0] code_b_o,
  output logic [DATA_W-1:0] ofs_a_o,
  output logic [DATA_W-1:0] ofs_b_o,
  output logic              shutdown_o,
  output logic              load_a_o,
  output logic              load_b_o
);
  logic [2:0]                     in_s;
  logic                           frame_n_s;
  logic [WORD_W-1:0]              shift_q;
  logic                           frame_end;
  ch_sel_e                        sel;
  logic [N_CH-1:0][DATA_W-1:0]    code_w;
  logic [N_CH-1:0][DATA_W-1:0]    ofs_w;
  logic [N_CH-1:0]                stb_w;

  dac_sync2 #(.W(3), .RST_VAL(IN_IDLE)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({frame_n_i, sdat_i, sclk_i}),
    .q_o   (in_s)
  );

  assign frame_n_s = in_s[2];

  dac_serial_front #(.WORD_W(WORD_W)) u_front (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk_s      (in_s[0]),
    .sdat_s      (in_s[1]),
    .frame_n_s   (frame_n_s),
    .shift_q     (shift_q),
    .frame_end_o (frame_end)
  );

  assign sel = ch_sel_e'(shift_q[ADDR_BIT]);

  dac_chan_bank #(.DATA_W(DATA_W), .N_CH(N_CH)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .xfer_i   (frame_end),
    .sel_i    (sel),
    .data_i   (shift_q[DATA_W-1:0]),
    .sd_i     (shift_q[SD_BIT]),
    .code_o   (code_w),
    .ofs_o    (ofs_w),
    .strobe_o (stb_w),
    .sd_o     (shutdown_o)
  );

  assign code_a_o = code_w[CH_A];
  assign code_b_o = code_w[CH_B];
  assign ofs_a_o  = ofs_w[CH_A];
  assign ofs_b_o  = ofs_w[CH_B];
  assign load_a_o = stb_w[CH_A];
  assign load_b_o = stb_w[CH_B];
endmodule

// File: rtl/dual_dac_serial_if_chk.sv
module dual_dac_serial_if_chk
  import dac_if_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] code_a_o,
  input logic [DATA_W-1:0] code_b_o,
  input logic [DATA_W-1:0] ofs_a_o,
  input logic [DATA_W-1:0] ofs_b_o,
  input logic              shutdown_o,
  input logic              load_a_o,
  input logic              load_b_o,
  input logic              frame_n_s,
  input logic [WORD_W-1:0] shift_q
);
  localparam logic [DATA_W-1:0] OFS_BIAS = DATA_W'(1) << (DATA_W - 1);

  p_strobe_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_a_o, load_b_o}));

  p_strobe_pulse_a_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load_a_o |=> !load_a_o);

  p_strobe_pulse_b_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load_b_o |=> !load_b_o);

  p_code_a_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load_a_o |-> $stable(code_a_o));

  p_code_b_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load_b_o |-> $stable(code_b_o));

  p_ofs_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ofs_a_o + OFS_BIAS) == code_a_o);

  p_ofs_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ofs_b_o + OFS_BIAS) == code_b_o);

  p_sd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_a_o || load_b_o) |-> $stable(shutdown_o));

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_n_s |=> $stable(shift_q));
endmodule

bind dual_dac_serial_if dual_dac_serial_if_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .code_a_o   (code_a_o),
  .code_b_o   (code_b_o),
  .ofs_a_o    (ofs_a_o),
  .ofs_b_o    (ofs_b_o),
  .shutdown_o (shutdown_o),
  .load_a_o   (load_a_o),
  .load_b_o   (load_b_o),
  .frame_n_s  (frame_n_s),
  .shift_q    (shift_q)
);

// File: tb/dual_dac_serial_if_bench.sv
module dual_dac_serial_if_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        sdat = 1'b0;
  logic        frame_n = 1'b1;
  logic [11:0] code_a, code_b, ofs_a, ofs_b;
  logic        sd, la, lb;

  int    n_chk = 0;
  int    n_fail = 0;
  int    cnt_la = 0;
  int    cnt_lb = 0;
  bit    done = 1'b0;
  bit    model_ok = 1'b0;
  string cur_req = "R1";

  // reference model state
  logic [2:0]  hist[$];
  logic [15:0] m_sr;
  logic [11:0] m_a, m_b;
  logic        m_sd, m_la, m_lb;

  always #4 clk = ~clk;

  dual_dac_serial_if u_dual_dac_serial_if (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdat_i(sdat), .frame_n_i(frame_n),
    .code_a_o(code_a), .code_b_o(code_b), .ofs_a_o(ofs_a), .ofs_b_o(ofs_b),
    .shutdown_o(sd), .load_a_o(la), .load_b_o(lb)
  );

  // Behavioural model: an input reaches the edge detector two edges late.
  always @(posedge clk) begin
    logic [2:0] s_now, s_old;
    if (!rst_n) begin
      hist = '{3'b100, 3'b100, 3'b100};
      m_sr = '0; m_a = '0; m_b = '0; m_sd = 1'b0; m_la = 1'b0; m_lb = 1'b0;
      model_ok = 1'b0;
    end else begin
      s_now = hist[1];
      s_old = hist[2];
      m_la = 1'b0;
      m_lb = 1'b0;
      if (!s_now[2] && s_now[0] && !s_old[0]) m_sr = {m_sr[14:0], s_now[1]};
      if (s_now[2] && !s_old[2]) begin
        if (m_sr[15]) begin m_b = m_sr[11:0]; m_lb = 1'b1; end
        else          begin m_a = m_sr[11:0]; m_la = 1'b1; end
        m_sd = m_sr[13];
      end
      hist.push_front({frame_n, sdat, sclk});
      void'(hist.pop_back());
      model_ok = 1'b1;
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && model_ok && !done) begin
      logic [50:0] act, exp;
      act = {code_a, code_b, ofs_a, ofs_b, sd, la, lb};
      exp = {m_a, m_b, ~m_a[11], m_a[10:0], ~m_b[11], m_b[10:0], m_sd, m_la, m_lb};
      n_chk++;
      if (act !== exp) begin
        n_fail++;
        $display("FAIL %s per-cycle: actual %h expected %h at %0t", cur_req, act, exp, $time);
      end
      if (la) cnt_la++;
      if (lb) cnt_lb++;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  function automatic logic [15:0] mk(input logic adr, input logic dc, input logic s,
                                     input logic rsv, input logic [11:0] d);
    return {adr, dc, s, rsv, d};
  endfunction

  task automatic send(input logic [31:0] bits, input int n, input bit collide);
    frame_n = 1'b0;
    wait_cyc(3);
    for (int i = n - 1; i >= 0; i--) begin
      sdat = bits[i]; sclk = 1'b0; wait_cyc(3);
      sclk = 1'b1; wait_cyc(3);
    end
    sclk = 1'b0;
    wait_cyc(3);
    if (collide) begin sdat = 1'b1; sclk = 1'b1; end
    frame_n = 1'b1;
    wait_cyc(8);
    sclk = 1'b0; sdat = 1'b0;
    wait_cyc(3);
  endtask

  initial begin
    int pa, pb;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(2);
    cur_req = "R1";
    chk("R1 code_a", {4'h0, code_a}, 16'h0000);
    chk("R1 code_b", {4'h0, code_b}, 16'h0000);
    chk("R1 ofs_a",  {4'h0, ofs_a}, 16'h0800);
    chk("R1 sd/strobes", {13'h0, sd, la, lb}, 16'h0000);
    pa = cnt_la;
    send(32'h0, 0, 1'b0);
    chk("R1 empty frame loads zero to A", {4'h0, code_a}, 16'h0000);
    chk("R10 one strobe on A", 16'(cnt_la - pa), 16'd1);

    cur_req = "R2";
    send({16'h0, mk(1'b0, 1'b0, 1'b0, 1'b0, 12'h7FF)}, 16, 1'b0);
    chk("R2 +full scale to A", {4'h0, code_a}, 16'h07FF);
    chk("R9 ofs_a of 0x7FF", {4'h0, ofs_a}, 16'h0FFF);
    cur_req = "R3";
    pa = cnt_la; pb = cnt_lb;
    send({16'h0, mk(1'b1, 1'b0, 1'b0, 1'b0, 12'h800)}, 16, 1'b0);
    chk("R3 -full scale to B", {4'h0, code_b}, 16'h0800);
    chk("R3 A holds", {4'h0, code_a}, 16'h07FF);
    chk("R9 ofs_b of 0x800", {4'h0, ofs_b}, 16'h0000);
    chk("R10 B strobe only", {16'(cnt_la - pa)}, 16'd0);
    chk("R10 B strobe once", {16'(cnt_lb - pb)}, 16'd1);
    send({16'h0, mk(1'b0, 1'b0, 1'b0, 1'b0, 12'hFFF)}, 16, 1'b0);
    chk("R2 -1 LSB to A", {4'h0, code_a}, 16'h0FFF);
    send({16'h0, mk(1'b1, 1'b0, 1'b0, 1'b0, 12'h801)}, 16, 1'b0);
    chk("R2 -FS+1 to B", {4'h0, code_b}, 16'h0801);

    cur_req = "R7";
    send({16'h0, mk(1'b1, 1'b0, 1'b1, 1'b0, 12'h055)}, 16, 1'b0);
    chk("R7 shutdown set via B", {15'h0, sd}, 16'h0001);
    send({16'h0, mk(1'b0, 1'b0, 1'b0, 1'b0, 12'h0AA)}, 16, 1'b0);
    chk("R7 shutdown cleared via A", {15'h0, sd}, 16'h0000);

    cur_req = "R8";
    send({16'h0, mk(1'b0, 1'b1, 1'b0, 1'b1, 12'h123)}, 16, 1'b0);
    chk("R8 code_a ignores bits 14/12", {4'h0, code_a}, 16'h0123);
    chk("R8 shutdown ignores bits 14/12", {15'h0, sd}, 16'h0000);

    cur_req = "R4";
    for (int k = 0; k < 5; k++) begin
      sdat = 1'b1; sclk = 1'b1; wait_cyc(3);
      sclk = 1'b0; wait_cyc(3);
    end
    sdat = 1'b0;
    send(32'h0, 0, 1'b0);
    chk("R4 idle clocks ignored", {4'h0, code_a}, 16'h0123);
    chk("R4 idle clocks ignored sd", {15'h0, sd}, 16'h0000);

    cur_req = "R6";
    send({16'h0, mk(1'b1, 1'b0, 1'b0, 1'b0, 12'hABC)}, 16, 1'b0);
    send(32'h5, 4, 1'b0);
    chk("R6 short frame code_b", {4'h0, code_b}, 16'h0BC5);
    chk("R6 short frame sd", {15'h0, sd}, 16'h0001);

    cur_req = "R5";
    send({12'h0, 4'hF, mk(1'b0, 1'b0, 1'b0, 1'b0, 12'h456)}, 20, 1'b0);
    chk("R5 long frame code_a", {4'h0, code_a}, 16'h0456);
    chk("R5 long frame sd", {15'h0, sd}, 16'h0000);

    cur_req = "R11";
    send({16'h0, mk(1'b1, 1'b0, 1'b0, 1'b0, 12'h3C3)}, 16, 1'b1);
    chk("R11 collision edge dropped", {4'h0, code_b}, 16'h03C3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion (%s)", cur_req);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule